// File: doc/BRIEF.md
# Carry Skip Adder

This block adds two unsigned or two's-complement operands plus a single carry-in bit and produces the sum together with the carry leaving the top bit. The operand width is divided into equal slices. Inside each slice the carry ripples from bit to bit, and a detector checks whether every position in the slice passes an incoming carry through unchanged, meaning the two operand bits differ. When that holds, a multiplexer sends the slice's incoming carry straight to the next slice and the ripple chain is bypassed. Otherwise the slice's own rippled carry is passed on.

The adder itself is combinational. The sum, the carry-out and the per-slice bypass flags are captured in one output register. A result therefore appears one clock after its operands are sampled. The bypass flags are brought out so that a bench can see which slices took the fast path on each addition.

Top module: `csk_adder_top`

## Requirements
- R1: One clock edge after `a_i`, `b_i` and `cin_i` are sampled with `rst` low, `sum_o` holds the low WIDTH bits of `a_i + b_i + cin_i`.
- R2: In the same cycle, `cout_o` holds bit WIDTH of `a_i + b_i + cin_i`, which is the carry out of the top bit.
- R3: Bit k of `skip_o` is 1 exactly when `a_i ^ b_i` is all ones over bits k*SECT_W through k*SECT_W+SECT_W-1 of the sampled operands. Slice 0 holds the least significant bits. The flag is registered in the same cycle as the sum.
- R4: A slice whose bypass flag is set passes its incoming carry to its outgoing carry. A carry made in a lower slice therefore reaches the top across any number of fully propagating slices above it. For example, 0x5558 + 0xAAA8 gives sum 0x0000 and carry-out 1.
- R5: When every bit propagates (`a_i ^ b_i` all ones), the sum is all ones with carry-out 0 for carry-in 0, and all zeros with carry-out 1 for carry-in 1. For example, a slice of 0101 plus 1010 with carry-in 1 gives 0000 and carry 1.
- R6: A slice that has at least one non-propagating position produces the same outgoing carry for either value of its incoming carry. For example, with 0101 plus 1001 in slice 0 and propagating slices above it, bits WIDTH-1 through SECT_W of `sum_o` and `cout_o` do not change when `cin_i` toggles.
- R7: A synchronous active-high `rst` clears `sum_o`, `cout_o` and `skip_o` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |
| skip_o | output | WIDTH/SECT_W | Registered per-slice bypass flags, bit 0 for the lowest slice |

## Verification
The assertions assume that the operands and carry-in are stable and fully driven at every sampling edge. They also assume that reset is held for at least one edge before the first checked result, because each result property compares the registered outputs with the inputs sampled one edge earlier. The stimulus changes its inputs only on falling edges and keeps reset high from time zero through the first rising edges. Random operands rarely make a whole slice propagate, so directed operands with `a_i ^ b_i` all ones in selected slices exercise the bypass path. They also cover a carry generated low and carried through every upper slice, and a carry-in toggle under a slice that blocks it.

// File: rtl/csk_pkg.sv
package csk_pkg;

  function automatic int unsigned slice_count(input int unsigned total_w,
                                              input int unsigned slice_w);
    return total_w / slice_w;
  endfunction

  function automatic bit slice_fits(input int unsigned total_w,
                                    input int unsigned slice_w);
    return (slice_w != 0) && ((total_w % slice_w) == 0);
  endfunction

endpackage

// File: rtl/csk_slice.sv
module csk_slice #(
  parameter int unsigned SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               c_in,
  output logic [SLICE_W-1:0] sum,
  output logic               c_ripple,
  output logic               c_out,
  output logic               bypass
);

  logic [SLICE_W-1:0] prop;
  logic [SLICE_W:0]   chain;

  assign prop   = a ^ b;
  assign bypass = &prop;

  always_comb begin
    chain[0] = c_in;
    for (int i = 0; i < SLICE_W; i++) begin
      sum[i]     = prop[i] ^ chain[i];
      chain[i+1] = (a[i] & b[i]) | (prop[i] & chain[i]);
    end
  end

  assign c_ripple = chain[SLICE_W];

  // bypass multiplexer: incoming carry jumps the slice when all positions propagate
  assign c_out = bypass ? c_in : c_ripple;

endmodule

// File: rtl/csk_core.sv
module csk_core #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SECT_W = 4,
  localparam int unsigned NSECT = csk_pkg::slice_count(WIDTH, SECT_W)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic [NSECT-1:0] bypass,
  output logic [NSECT:0]   carry,
  output logic [NSECT-1:0] ripple
);

  assign carry[0] = cin;

  for (genvar k = 0; k < NSECT; k++) begin : g_slice
    csk_slice #(.SLICE_W(SECT_W)) u_slice (
      .a        (a[k*SECT_W +: SECT_W]),
      .b        (b[k*SECT_W +: SECT_W]),
      .c_in     (carry[k]),
      .sum      (sum[k*SECT_W +: SECT_W]),
      .c_ripple (ripple[k]),
      .c_out    (carry[k+1]),
      .bypass   (bypass[k])
    );
  end

  assign cout = carry[NSECT];

endmodule

// File: rtl/csk_adder_top.sv
module csk_adder_top #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SECT_W = 4,
  localparam int unsigned NSECT = csk_pkg::slice_count(WIDTH, SECT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [NSECT-1:0] skip_o
);

  if (!csk_pkg::slice_fits(WIDTH, SECT_W)) begin : g_bad_split
    $error("csk_adder_top: SECT_W must divide WIDTH exactly");
  end

  logic [WIDTH-1:0] sum_c;
  logic             cout_c;
  logic [NSECT-1:0] skip_c;
  logic [NSECT:0]   carry_c;
  logic [NSECT-1:0] ripple_c;

  csk_core #(.WIDTH(WIDTH), .SECT_W(SECT_W)) u_core (
    .a      (a_i),
    .b      (b_i),
    .cin    (cin_i),
    .sum    (sum_c),
    .cout   (cout_c),
    .bypass (skip_c),
    .carry  (carry_c),
    .ripple (ripple_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
      skip_o <= '0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= cout_c;
      skip_o <= skip_c;
    end
  end

  // R1 and R2: registered result equals arithmetic sum of the previous sample
  assert_sum_matches_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}
                                  + {{WIDTH{1'b0}}, $past(cin_i)})));

  // R5: with every slice bypassing, carry-out follows carry-in
  assert_full_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (&skip_o) |-> (cout_o == $past(cin_i)));

  for (genvar k = 0; k < NSECT; k++) begin : g_chk
    // R3: flag reflects all-propagate condition of the sampled slice
    assert_flag_R3: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (skip_o[k] == &($past(a_i[k*SECT_W +: SECT_W])
                               ^ $past(b_i[k*SECT_W +: SECT_W]))));
    // R4: when bypassing, the ripple chain agrees with the carry that skipped it
    assert_bypass_exact_R4: assert property (@(posedge clk) disable iff (rst)
      skip_c[k] |-> (ripple_c[k] == carry_c[k]));
  end

endmodule

// File: tb/tb_csk_adder_top.sv
module tb_csk_adder_top;

  localparam int unsigned W  = 16;
  localparam int unsigned SW = 4;
  localparam int unsigned NS = W / SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a   = '0;
  logic [W-1:0]  b   = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;
  logic [NS-1:0] skip;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  csk_adder_top #(.WIDTH(W), .SECT_W(SW)) dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .skip_o(skip)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [NS-1:0] ref_skip(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [NS-1:0] r;
    logic [W-1:0]  p;
    p = x ^ y;
    for (int k = 0; k < NS; k++) r[k] = &p[k*SW +: SW];
    return r;
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] e;
    @(negedge clk);
    a = x; b = y; cin = c;
    @(posedge clk);
    #1;
    e = ref_add(x, y, c);
    check("R1 sum", {1'b0, sum}, {1'b0, e[W-1:0]});
    check("R2 cout", {{W{1'b0}}, cout}, {{W{1'b0}}, e[W]});
    check("R3 skip", {{(W+1-NS){1'b0}}, skip}, {{(W+1-NS){1'b0}}, ref_skip(x, y)});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] hi0, hi1;
    logic         co0, co1;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    check("R7 reset sum", {1'b0, sum}, '0);
    check("R7 reset cout/skip", {{(W-NS){1'b0}}, cout, skip}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R5: every slice propagates
    apply(16'h5555, 16'hAAAA, 1'b1);
    check("R5 all-prop cin1", {cout, sum}, {1'b1, 16'h0000});
    apply(16'h5555, 16'hAAAA, 1'b0);
    check("R5 all-prop cin0", {cout, sum}, {1'b0, 16'hFFFF});
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R5 ones+cin", {cout, sum}, {1'b1, 16'h0000});

    // R4: carry made in slice 0 crosses three bypassing slices
    apply(16'h5558, 16'hAAA8, 1'b0);
    check("R4 skip flags", {{(W+1-NS){1'b0}}, skip}, {{(W+1-NS){1'b0}}, 4'b1110});
    check("R4 carry across", {cout, sum}, {1'b1, 16'h0000});

    // R6: slice 0 blocks, upper slices unaffected by carry-in
    apply(16'h5555, 16'hAAA9, 1'b0);
    hi0 = sum; co0 = cout;
    apply(16'h5555, 16'hAAA9, 1'b1);
    hi1 = sum; co1 = cout;
    check("R6 upper bits independent", {5'b0, co1, hi1[W-1:SW]}, {5'b0, co0, hi0[W-1:SW]});
    check("R6 no carry out", {{W{1'b0}}, co1}, '0);

    // corners
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h0000, 16'h0000, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0);

    // random mix, some with forced propagating slices
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x, y, m;
      x = W'($urandom);
      m = W'($urandom);
      y = (i % 3 == 0) ? (~x ^ (m & 16'h0F0F & W'($urandom))) : W'($urandom);
      apply(x, y, 1'($urandom));
    end

    // R7: reset mid-run
    apply(16'h1234, 16'h4321, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R7 mid-run reset", {cout, sum}, '0);
    check("R7 mid-run skip", {{(W+1-NS){1'b0}}, skip}, '0);

    done = 1'b1;
    finish_run();
  end

endmodule